// File: doc/BRIEF.md
# Diagnostic Line Slow-Initialization Pulse Generator

This block produces the two legacy wake-up sequences of a single-wire vehicle diagnostic bus on one or both of its two lines, called K and L here. A command strobe starts either a short wake-up pulse or a slow address frame. The wake-up pulse is low for one bit and then high for one bit. The address frame is a start bit, an 8-bit target address and a stop bit, sent at five bits per second. While a sequence runs, the block takes the selected pins away from the normal UART, drives them directly and pulses an activity LED with the line level. When the last bit ends, the block hands the pins back.

Timing comes from a base tick of `TICK_DIV` clock cycles. With a clock of 1 MHz after prescaling and `TICK_DIV` = 5000, the base tick is 5 ms. Bit times are whole numbers of base ticks: `ADDR_TICKS` (40, which gives 200 ms) per address bit and `WAKE_TICKS` (5, which gives 25 ms) per wake-up bit. The start strobe is a plain command, not a stream handshake, so it has no back-pressure. A strobe is either taken, which pulses `accept`, or refused, which pulses `reject`. The block never holds a strobe for later.

Top module: `kline_init_gen`

## Requirements
- R1: After reset, `busy`, `done`, `accept`, `reject`, `k_own`, `l_own` and `led` are 0, and `k_lvl` and `l_lvl` are 1.
- R2: A `start` while idle with `line_sel` 0 (K only), 1 (L only) or 2 (both) gives a one-cycle `accept` and raises `busy` on the next edge. At that same edge the selected lines become owned (`*_own` = 1) and are driven high. They stay high for the first base tick.
- R3: A `start` with `line_sel` = 3 gives a one-cycle `reject` and starts nothing. The block stays idle with its lines released.
- R4: A `start` while `busy` gives a one-cycle `reject`. The running sequence continues with its own mode, address and lines, even if the inputs have changed.
- R5: In address mode (`mode` = 1), the line carries 10 bits of `ADDR_TICKS` base ticks each. Bit 0 is a low start bit. Bits 1 to 8 are `addr[0]` to `addr[7]`. Bit 9 is a high stop bit.
- R6: In wake-up mode (`mode` = 0), the line carries 2 bits of `WAKE_TICKS` base ticks each: low first, then high.
- R7: A line that is not selected stays released for the whole sequence (`*_own` = 0 and level 1).
- R8: Exactly (1 + bits × bit_ticks) base ticks after the accepting edge, `done` pulses for one cycle. In that same cycle `busy` clears, both owns drop and both levels return to 1.
- R9: `led` equals the driven line level while `busy` and is 0 when idle.
- R10: Each base tick is `TICK_DIV` clock cycles, and the tick count restarts at every accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, sampled each edge |
| mode | input | 1 | 0 = wake-up pulse, 1 = address frame |
| addr | input | 8 | Target address for address mode |
| line_sel | input | 2 | 0 = K, 1 = L, 2 = both, 3 = invalid |
| k_own | output | 1 | 1: K pin driven by this block, 0: by UART |
| l_own | output | 1 | 1: L pin driven by this block, 0: by UART |
| k_lvl | output | 1 | K drive level (1 when not owned) |
| l_lvl | output | 1 | L drive level (1 when not owned) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| accept | output | 1 | One-cycle pulse: start taken |
| reject | output | 1 | One-cycle pulse: start refused |
| led | output | 1 | Activity indicator following line level |

## Verification
The hardest situation to bring about is a second start that arrives in the middle of a running frame and carries different mode, address and line fields. If any of those fields leaked into the running frame, the corruption would show only in later bits. The bench raises such a strobe mid-frame on part of the sweep and keeps comparing every cycle until `done`. It also sweeps all 256 addresses over the three valid line codes, using a short tick so that each final-bit boundary is checked cycle by cycle.

// File: rtl/kinit_pkg.sv
package kinit_pkg;
  localparam int FRAME_W = 10;

  typedef enum logic {
    MODE_WAKE = 1'b0,
    MODE_ADDR = 1'b1
  } kinit_mode_e;

  // bit 0 leaves first
  function automatic logic [FRAME_W-1:0] kinit_frame(kinit_mode_e m, logic [7:0] a);
    if (m == MODE_ADDR) return {1'b1, a, 1'b0};
    return {{(FRAME_W-2){1'b0}}, 2'b10};
  endfunction
endpackage

// File: rtl/kinit_tick.sv
module kinit_tick #(
  parameter int DIV = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/kinit_ser.sv
module kinit_ser
  import kinit_pkg::*;
#(
  parameter int ADDR_TICKS = 40,
  parameter int WAKE_TICKS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  kinit_mode_e mode,
  input  logic [7:0]  addr,
  input  logic        tick,
  output logic        active,
  output logic        level,
  output logic        fin
);
  localparam int MAXT = (ADDR_TICKS > WAKE_TICKS) ? ADDR_TICKS : WAKE_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int IW   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [TW-1:0]      tcnt, tlast;
  logic [IW-1:0]      bidx, blast;
  logic               lead;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; level <= 1'b1; fin <= 1'b0; lead <= 1'b0;
      shreg <= '0; tcnt <= '0; tlast <= '0; bidx <= '0; blast <= '0;
    end else begin
      fin <= 1'b0;
      if (load && !active) begin
        active <= 1'b1;
        lead   <= 1'b1;
        level  <= 1'b1;
        shreg  <= kinit_frame(mode, addr);
        tcnt   <= '0;
        bidx   <= '0;
        blast  <= (mode == MODE_ADDR) ? IW'(FRAME_W - 1) : IW'(1);
        tlast  <= (mode == MODE_ADDR) ? TW'(ADDR_TICKS - 1) : TW'(WAKE_TICKS - 1);
      end else if (active && tick) begin
        if (lead) begin
          lead  <= 1'b0;
          level <= shreg[0];
        end else if (tcnt == tlast) begin
          tcnt <= '0;
          if (bidx == blast) begin
            active <= 1'b0;
            fin    <= 1'b1;
            level  <= 1'b1;
          end else begin
            bidx  <= bidx + 1'b1;
            shreg <= shreg >> 1;
            level <= shreg[1];
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kinit_lines.sv
module kinit_lines (
  input  logic active,
  input  logic level,
  input  logic k_sel,
  input  logic l_sel,
  output logic k_own,
  output logic l_own,
  output logic k_lvl,
  output logic l_lvl,
  output logic led
);
  always_comb begin
    k_own = active & k_sel;
    l_own = active & l_sel;
    k_lvl = k_own ? level : 1'b1;
    l_lvl = l_own ? level : 1'b1;
    led   = active & level;
  end
endmodule

// File: rtl/kline_init_gen.sv
module kline_init_gen
  import kinit_pkg::*;
#(
  parameter int TICK_DIV   = 5000,
  parameter int ADDR_TICKS = 40,
  parameter int WAKE_TICKS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mode,
  input  logic [7:0] addr,
  input  logic [1:0] line_sel,
  output logic       k_own,
  output logic       l_own,
  output logic       k_lvl,
  output logic       l_lvl,
  output logic       busy,
  output logic       done,
  output logic       accept,
  output logic       reject,
  output logic       led
);
  logic sel_ok, take, tick, active, level, k_sel_q, l_sel_q;

  assign sel_ok = (line_sel != 2'd3);
  assign take   = start && !active && sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept <= 1'b0; reject <= 1'b0; k_sel_q <= 1'b0; l_sel_q <= 1'b0;
    end else begin
      accept <= take;
      reject <= start && !take;
      if (take) begin
        k_sel_q <= (line_sel == 2'd0) || (line_sel == 2'd2);
        l_sel_q <= (line_sel == 2'd1) || (line_sel == 2'd2);
      end
    end
  end

  kinit_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(active), .tick(tick)
  );

  kinit_ser #(.ADDR_TICKS(ADDR_TICKS), .WAKE_TICKS(WAKE_TICKS)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(take), .mode(kinit_mode_e'(mode)),
    .addr(addr), .tick(tick), .active(active), .level(level), .fin(done)
  );

  kinit_lines u_lines (
    .active(active), .level(level), .k_sel(k_sel_q), .l_sel(l_sel_q),
    .k_own(k_own), .l_own(l_own), .k_lvl(k_lvl), .l_lvl(l_lvl), .led(led)
  );

  assign busy = active;
endmodule

// File: rtl/kinit_chk.sv
module kinit_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic accept,
  input logic reject,
  input logic k_own,
  input logic l_own,
  input logic k_lvl,
  input logic l_lvl,
  input logic led
);
  a_r3_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept, reject}));

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!k_own && !l_own && k_lvl && l_lvl && !led));

  a_r2_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (busy && k_lvl && l_lvl && (k_own || l_own)));

  a_r2_busy_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> accept);

  a_r4_busy_survives_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && $past(busy)) |-> (busy || done));

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r9_led_tracks_k: assert property (@(posedge clk) disable iff (!rst_n)
    k_own |-> (led == k_lvl));

  a_r9_led_tracks_l: assert property (@(posedge clk) disable iff (!rst_n)
    l_own |-> (led == l_lvl));
endmodule

bind kline_init_gen kinit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .accept(accept),
  .reject(reject), .k_own(k_own), .l_own(l_own), .k_lvl(k_lvl),
  .l_lvl(l_lvl), .led(led)
);

// File: tb/kline_init_gen_tb.sv
`timescale 1ns/1ps
module kline_init_gen_tb;
  localparam int D  = 2;
  localparam int TA = 3;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [7:0] addr = '0;
  logic [1:0] line_sel = '0;
  logic k_own, l_own, k_lvl, l_lvl, busy, done, accept, reject, led;
  int total_n = 0;
  int bad_n = 0;

  always #2 clk = ~clk;

  kline_init_gen #(.TICK_DIV(D), .ADDR_TICKS(TA), .WAKE_TICKS(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr(addr),
    .line_sel(line_sel), .k_own(k_own), .l_own(l_own), .k_lvl(k_lvl),
    .l_lvl(l_lvl), .busy(busy), .done(done), .accept(accept),
    .reject(reject), .led(led)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total_n++;
    if (got !== exp) begin
      bad_n++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic frame_bit(input logic m, input logic [7:0] a, input int j);
    if (m) begin
      if (j == 0) return 1'b0;
      if (j == 9) return 1'b1;
      return a[j-1];
    end
    return (j == 1);
  endfunction

  task automatic run_seq(input logic m, input logic [7:0] a, input logic [1:0] s, input bit poke);
    int nbits = m ? 10 : 2;
    int tpb   = m ? TA : TW;
    int total = (1 + nbits * tpb) * D;
    logic ks = (s == 2'd0) || (s == 2'd2);
    logic ls = (s == 2'd1) || (s == 2'd2);
    @(negedge clk);
    start = 1'b1; mode = m; addr = a; line_sel = s;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= total; k++) begin
      int n = k / D;
      logic eb = (k < total);
      logic lv = (n == 0 || !eb) ? 1'b1 : frame_bit(m, a, (n - 1) / tpb);
      if (k > 0) @(negedge clk);
      if (poke && k == 4) begin
        start = 1'b1; mode = ~m; addr = ~a; line_sel = (s == 2'd2) ? 2'd0 : 2'd2;
      end
      if (poke && k == 5) start = 1'b0;
      chk("R8 busy", {7'd0, busy}, {7'd0, eb});
      chk("R8 done", {7'd0, done}, {7'd0, (k == total)});
      chk("R2 accept", {7'd0, accept}, {7'd0, (k == 0)});
      chk("R4 reject", {7'd0, reject}, {7'd0, (poke && k == 5)});
      chk("R7 own", {6'd0, k_own, l_own}, {6'd0, eb & ks, eb & ls});
      chk(m ? "R5 level" : "R6 level", {6'd0, k_lvl, l_lvl},
          {6'd0, ks ? lv : 1'b1, ls ? lv : 1'b1});
      chk("R9 led", {7'd0, led}, {7'd0, eb & lv});
      if (k == D - 1) chk("R10 first tick hold", {7'd0, k_lvl & l_lvl}, 8'd1);
    end
  endtask

  initial begin
    #800000;
    bad_n++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 idle flags", {4'd0, busy, done, accept, reject}, 8'd0);
    chk("R1 idle lines", {4'd0, k_own, l_own, k_lvl, l_lvl}, 8'b0000_0011);
    chk("R1 idle led", {7'd0, led}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {3'd0, busy, k_own, l_own, k_lvl, l_lvl}, 8'b0000_0011);

    // R3: invalid line code
    start = 1'b1; mode = 1'b1; addr = 8'h5A; line_sel = 2'd3;
    @(negedge clk);
    start = 1'b0;
    chk("R3 reject", {6'd0, accept, reject}, 8'd1);
    chk("R3 idle", {3'd0, busy, k_own, l_own, k_lvl, l_lvl}, 8'b0000_0011);
    repeat (4) @(negedge clk);
    chk("R3 still idle", {3'd0, busy, k_own, l_own, k_lvl, l_lvl}, 8'b0000_0011);

    // R6: wake-up on each line code, with and without a mid-sequence strobe
    for (int s = 0; s < 3; s++) begin
      run_seq(1'b0, 8'h00, s[1:0], 1'b0);
      run_seq(1'b0, 8'hFF, s[1:0], 1'b1);
    end

    // R5: every address on every valid line code
    for (int a = 0; a < 256; a++) begin
      for (int s = 0; s < 3; s++) begin
        run_seq(1'b1, a[7:0], s[1:0], (a % 37) == s);
      end
    end

    @(negedge clk);
    chk("R1 idle at end", {3'd0, busy, k_own, l_own, k_lvl, l_lvl}, 8'b0000_0011);
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule